// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two 18-bit buses, called A and B, in both directions. Each direction has its own storage word and its own controls: a level-sensitive follow control, a capture clock with an active-low gate, and an active-low drive enable. The follow control makes storage track the source bus. With the follow control low, storage either holds its word or takes a new one on a rising edge of the direction's capture clock, and the edge counts only while the gate is open. A three-state driver puts the stored word onto the opposite bus, or leaves that bus undriven.

The block runs on one core clock. The direction capture clocks and the follow controls are sampled as levels on that clock. A capture edge is a capture-clock level that was low on the previous core cycle and is high on this one. Both buses are inout nets. A board-level agent or a neighbouring block drives a bus whenever this block leaves it released. A synchronous test reset clears both storage words for simulation.

Top module: `ubt_bus_xcvr`

## Requirements
- R1: The data path is WIDTH bits (default 18) in each direction, and every bit, including the most significant, passes from source bus to storage to the opposite bus.
- R2: While a direction's follow control is high, its storage loads the source bus on every core clock edge. The opposite bus, when enabled, shows that word after the edge.
- R3: While the follow control is low and no capture edge occurs, storage keeps its word. After the follow control falls, the last word loaded while it was high is held, even if the source bus changes.
- R4: With the follow control low and the capture gate low (0 = open), storage loads the source bus on the core edge where the capture clock is first seen high after being low on the previous core edge.
- R5: While the capture gate is high (1 = closed), capture-clock rising edges leave storage unchanged.
- R6: When a direction's drive enable is high (1 = off), the block does not drive the opposite bus, and an external agent's value reads back unaltered. When it is low (0 = on), that bus carries the direction's storage word.
- R7: The follow control has priority over the capture clock. Capture edges during follow mode change nothing beyond the follow behaviour.
- R8: The test reset (active high) clears both storage words to zero and treats both capture clocks as already high. A clock held high through reset therefore produces no capture until it has gone low and risen again.
- R9: The B-to-A direction behaves like the A-to-B direction with the buses swapped, using its own follow control, capture clock, capture gate and drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all controls and updates storage |
| rst | input | 1 | Synchronous test reset, active high |
| a_bus | inout | WIDTH | Bus A: source for A-to-B, driven by B-to-A storage |
| b_bus | inout | WIDTH | Bus B: source for B-to-A, driven by A-to-B storage |
| ab_follow | input | 1 | A-to-B follow control, high = storage tracks bus A |
| ab_cap_clk | input | 1 | A-to-B capture clock, rising edge captures |
| ab_cap_gate_n | input | 1 | A-to-B capture gate, low = edges honoured |
| ab_drive_n | input | 1 | A-to-B drive enable onto bus B, low = drive |
| ba_follow | input | 1 | B-to-A follow control, high = storage tracks bus B |
| ba_cap_clk | input | 1 | B-to-A capture clock, rising edge captures |
| ba_cap_gate_n | input | 1 | B-to-A capture gate, low = edges honoured |
| ba_drive_n | input | 1 | B-to-A drive enable onto bus A, low = drive |

## Verification
The bench builds the block with WIDTH at 18, SYNC_STAGES at 0 and CLEAR_ON_RESET at 1. With these values every capture lands on the first core edge that sees the new clock level, so a bench model can predict storage cycle by cycle. With the reset clearing storage, the post-reset hold rule and the all-ones word on the top bit are checked as exact values. Because both buses are always driven by exactly one party, a word the block should not drive reads back as the agent's value. When both drive enables are low, one direction's storage becomes the other's source, so the bench also covers that loop.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   // Control bundle for one transfer direction
   typedef struct packed {
      logic follow;
      logic cap_clk;
      logic cap_gate_n;
      logic drive_n;
   } ubt_dir_ctl_t;

   // Capture qualification: edge seen and gate open
   function automatic logic ubt_capture_ok(input logic rise, input logic gate_n);
      return rise & ~gate_n;
   endfunction

endpackage

// File: rtl/ubt_edge_detect.sv
module ubt_edge_detect #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);

   logic lvl_s;
   logic prev_q;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("ubt_edge_detect: SYNC_STAGES must be 0..4");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_s = lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], lvl} >> 0;
         end
         assign lvl_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // Previous level resets high so a held-high clock is not an edge (R8)
   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= lvl_s;
   end

   assign rise = lvl_s & ~prev_q;

   // R4: a rising edge is a single-cycle event
   a_r4_single_rise: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
   parameter int WIDTH          = 18,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             follow,
   input  logic             rise,
   input  logic             gate_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   import ubt_pkg::*;

   logic             load;
   logic [WIDTH-1:0] q_r;

   // Follow mode wins over any capture edge (R7)
   assign load = follow | ubt_capture_ok(rise, gate_n);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ubt_store: WIDTH must be at least 1");
      end

      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (rst)       q_r <= '0;
            else if (load) q_r <= din;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (load) q_r <= din;
         end
      end
   endgenerate

   assign q = q_r;

   // R2: follow mode loads the source every core edge
   a_r2_follow_load: assert property (@(posedge clk) disable iff (rst)
      follow |=> q == $past(din));

   // R3: no follow, no edge -> word held
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (!follow && !rise) |=> $stable(q));

   // R4: gated-open edge captures the source
   a_r4_capture: assert property (@(posedge clk) disable iff (rst)
      (!follow && rise && !gate_n) |=> q == $past(din));

   // R5: closed gate blocks capture
   a_r5_gate_closed: assert property (@(posedge clk) disable iff (rst)
      (!follow && gate_n) |=> $stable(q));

endmodule

// File: rtl/ubt_drive.sv
module ubt_drive #(
   parameter int WIDTH = 18
) (
   input  logic             drive_n,
   input  logic [WIDTH-1:0] d,
   inout  wire  [WIDTH-1:0] pad
);

   // R6: released when drive enable is high
   assign pad = drive_n ? {WIDTH{1'bz}} : d;

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
   parameter int WIDTH          = 18,
   parameter int SYNC_STAGES    = 0,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  ubt_pkg::ubt_dir_ctl_t ctl,
   input  logic [WIDTH-1:0]      src,
   inout  wire  [WIDTH-1:0]      dst
);

   logic             rise;
   logic [WIDTH-1:0] word;

   ubt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (ctl.cap_clk),
      .rise (rise)
   );

   ubt_store #(.WIDTH(WIDTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk    (clk),
      .rst    (rst),
      .follow (ctl.follow),
      .rise   (rise),
      .gate_n (ctl.cap_gate_n),
      .din    (src),
      .q      (word)
   );

   ubt_drive #(.WIDTH(WIDTH)) u_drive (
      .drive_n (ctl.drive_n),
      .d       (word),
      .pad     (dst)
   );

endmodule

// File: rtl/ubt_bus_xcvr.sv
module ubt_bus_xcvr #(
   parameter int WIDTH          = 18,
   parameter int SYNC_STAGES    = 0,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   inout  wire  [WIDTH-1:0] a_bus,
   inout  wire  [WIDTH-1:0] b_bus,
   input  logic             ab_follow,
   input  logic             ab_cap_clk,
   input  logic             ab_cap_gate_n,
   input  logic             ab_drive_n,
   input  logic             ba_follow,
   input  logic             ba_cap_clk,
   input  logic             ba_cap_gate_n,
   input  logic             ba_drive_n
);
   import ubt_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ubt_bus_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   ubt_dir_ctl_t ab_ctl;
   ubt_dir_ctl_t ba_ctl;

   assign ab_ctl = '{follow: ab_follow, cap_clk: ab_cap_clk,
                     cap_gate_n: ab_cap_gate_n, drive_n: ab_drive_n};
   assign ba_ctl = '{follow: ba_follow, cap_clk: ba_cap_clk,
                     cap_gate_n: ba_cap_gate_n, drive_n: ba_drive_n};

   // A-to-B lane: source bus A, drives bus B
   ubt_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES),
              .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_ab (
      .clk (clk),
      .rst (rst),
      .ctl (ab_ctl),
      .src (a_bus),
      .dst (b_bus)
   );

   // R9: B-to-A lane, same structure with buses swapped
   ubt_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES),
              .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_ba (
      .clk (clk),
      .rst (rst),
      .ctl (ba_ctl),
      .src (b_bus),
      .dst (a_bus)
   );

endmodule

// File: tb/ubt_bus_xcvr_test.sv
`timescale 1ns/1ps
module ubt_bus_xcvr_test;
   localparam int W = 18;

   logic clk = 1'b0;
   logic rst;
   logic ab_follow, ab_cap_clk, ab_cap_gate_n, ab_drive_n;
   logic ba_follow, ba_cap_clk, ba_cap_gate_n, ba_drive_n;
   logic [W-1:0] tb_a_val, tb_b_val;
   wire  [W-1:0] a_bus, b_bus;

   int total = 0;
   int bad   = 0;

   // External agents drive a bus whenever the block releases it
   assign a_bus = ba_drive_n ? tb_a_val : {W{1'bz}};
   assign b_bus = ab_drive_n ? tb_b_val : {W{1'bz}};

   always #4 clk = ~clk;  // 125 MHz

   ubt_bus_xcvr #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus),
      .ab_follow(ab_follow), .ab_cap_clk(ab_cap_clk),
      .ab_cap_gate_n(ab_cap_gate_n), .ab_drive_n(ab_drive_n),
      .ba_follow(ba_follow), .ba_cap_clk(ba_cap_clk),
      .ba_cap_gate_n(ba_cap_gate_n), .ba_drive_n(ba_drive_n)
   );

   // Reference model built from the requirements
   logic [W-1:0] exp_ab, exp_ba;
   logic prev_ab_clk, prev_ba_clk;

   function automatic logic [W-1:0] next_word(input logic r, input logic fol,
         input logic cclk, input logic prev, input logic gate_n,
         input logic [W-1:0] src, input logic [W-1:0] cur);
      if (r)                            return '0;
      if (fol)                          return src;
      if (cclk && !prev && !gate_n)     return src;
      return cur;
   endfunction

   always @(posedge clk) begin
      logic [W-1:0] a_now, b_now;
      a_now = ba_drive_n ? tb_a_val : exp_ba;
      b_now = ab_drive_n ? tb_b_val : exp_ab;
      exp_ab      <= next_word(rst, ab_follow, ab_cap_clk, prev_ab_clk, ab_cap_gate_n, a_now, exp_ab);
      exp_ba      <= next_word(rst, ba_follow, ba_cap_clk, prev_ba_clk, ba_cap_gate_n, b_now, exp_ba);
      prev_ab_clk <= rst ? 1'b1 : ab_cap_clk;
      prev_ba_clk <= rst ? 1'b1 : ba_cap_clk;
   end

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Compare both buses; a released bus must show the agent's value (R6)
   task automatic check_all(input string tag_ab, input string tag_ba);
      if (!ab_drive_n) chk(tag_ab, b_bus, exp_ab);
      else             chk("R6 bus B released", b_bus, tb_b_val);
      if (!ba_drive_n) chk(tag_ba, a_bus, exp_ba);
      else             chk("R6 bus A released", a_bus, tb_a_val);
   endtask

   function automatic string mode_tag(input logic fol, input logic newc,
         input logic oldc, input logic gate_n, input string dir);
      if (fol)                 return {dir, " R2/R7 follow"};
      if (newc && !oldc)       return gate_n ? {dir, " R5 gated"} : {dir, " R4 capture"};
      return {dir, " R3 hold"};
   endfunction

   initial begin
      #(8ns * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      string t_ab, t_ba;
      void'($urandom(32'h5eed_1234));
      // R8: clocks held high through reset, gates open, both drives on
      rst = 1'b1;
      ab_follow = 0; ab_cap_clk = 1; ab_cap_gate_n = 0; ab_drive_n = 0;
      ba_follow = 0; ba_cap_clk = 1; ba_cap_gate_n = 0; ba_drive_n = 0;
      tb_a_val = '0; tb_b_val = '0;
      repeat (3) tick();
      rst = 1'b0;
      tick();
      chk("R8 reset clears B-side word", b_bus, '0);
      chk("R8 reset clears A-side word", a_bus, '0);
      tb_a_val = 18'h1_2345; ba_drive_n = 1;
      tick();
      chk("R8 held-high clock is no edge", b_bus, '0);

      // R1 / R2 follow mode, full width
      ab_follow = 1; tb_a_val = {W{1'b1}};
      tick(); chk("R1 all ones pass A to B", b_bus, {W{1'b1}});
      tb_a_val = 18'h1_5A5A;
      tick(); chk("R2 follow tracks A", b_bus, 18'h1_5A5A);

      // R3 hand-off: follow falls, source changes, word held
      ab_follow = 0; ab_cap_clk = 0;
      tick();
      tb_a_val = 18'h0_F0F0;
      tick(); chk("R3 hand-off holds last word", b_bus, 18'h1_5A5A);

      // R4 capture on rising edge
      ab_cap_clk = 1;
      tick(); chk("R4 rising edge captures", b_bus, 18'h0_F0F0);

      // R5 gate closed
      ab_cap_gate_n = 1; tb_a_val = 18'h2_AAAA; ab_cap_clk = 0;
      tick(); ab_cap_clk = 1;
      tick(); chk("R5 closed gate ignores edge", b_bus, 18'h0_F0F0);

      // R7 follow has priority over edges
      ab_cap_gate_n = 0; ab_follow = 1; ab_cap_clk = 0; tb_a_val = 18'h0_0001;
      tick(); chk("R7 follow with clock low", b_bus, 18'h0_0001);
      ab_cap_clk = 1; tb_a_val = 18'h2_0000;
      tick(); chk("R7 follow with edge", b_bus, 18'h2_0000);

      // R6 drive off: agent value visible on B
      ab_drive_n = 1; tb_b_val = 18'h3_1337;
      tick(); chk("R6 B not driven", b_bus, 18'h3_1337);

      // R9 mirror direction
      ab_follow = 0; ba_drive_n = 0; ba_follow = 1; tb_b_val = 18'h0_BEEF;
      tick(); chk("R9 follow tracks B", a_bus, 18'h0_BEEF);
      ba_follow = 0; ba_cap_clk = 0;
      tick(); tb_b_val = 18'h1_CAFE;
      tick(); chk("R9 hand-off holds", a_bus, 18'h0_BEEF);
      ba_cap_clk = 1;
      tick(); chk("R9 edge captures", a_bus, 18'h1_CAFE);
      ba_cap_gate_n = 1; ba_cap_clk = 0; tb_b_val = 18'h0_0777;
      tick(); ba_cap_clk = 1;
      tick(); chk("R9 gated edge ignored", a_bus, 18'h1_CAFE);
      ba_drive_n = 1; tb_a_val = 18'h2_4680;
      tick(); chk("R6 A not driven", a_bus, 18'h2_4680);

      // Constrained random phase checked against the model
      for (int i = 0; i < 600; i++) begin
         logic nc_ab, nc_ba;
         nc_ab = 1'($urandom);
         nc_ba = 1'($urandom);
         t_ab = mode_tag(ab_follow, ab_cap_clk, prev_ab_clk, ab_cap_gate_n, "AB");
         t_ba = mode_tag(ba_follow, ba_cap_clk, prev_ba_clk, ba_cap_gate_n, "R9 BA");
         check_all(t_ab, t_ba);
         ab_follow     = ($urandom % 4) == 0;
         ba_follow     = ($urandom % 4) == 0;
         ab_cap_clk    = nc_ab;
         ba_cap_clk    = nc_ba;
         ab_cap_gate_n = ($urandom % 3) == 0;
         ba_cap_gate_n = ($urandom % 3) == 0;
         ab_drive_n    = 1'($urandom);
         ba_drive_n    = 1'($urandom);
         tb_a_val      = W'($urandom);
         tb_b_val      = W'($urandom);
         tick();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule